// File: doc/BRIEF.md
# Mode-Configurable Asynchronous-Control Register Slice

This block is a slice of `WIDTH` one-bit register cells of the kind found in a programmable logic element. Every cell is built from one primitive flip-flop that has only an asynchronous set path and an asynchronous reset path. Two control lines are shared by all cells of the slice: `ctl_a`, the first line, and `ctl_b`, the second. Each cell also has its own synchronous data bit and its own asynchronous load bit.

A static mode code decides how the two control lines and the load bit are steered onto the flip-flop's set and reset paths. The available behaviours are:

- clear-only;
- preset by a load of a constant one;
- preset by clearing behind inverted data and output;
- preset with clear;
- load with clear;
- load with preset;
- load-only.

Two static enables invert the data path before the flip-flop and the output after it. Two modes force both inversions on, so that a clear on the primitive shows as a one at the output. When no control is active, each cell captures its data bit on the rising clock edge. A synchronous active-low reset clears the stored bit on a clock edge.

The intended use is as the register stage behind a logic element's combinational function. Configuration is set once, and the control lines are driven by the slice's shared control routing.

Top module: `lecell_reg`

## Requirements
- R1: Mode code 0 (clear-only), and the spare code 7 in the same way: asserting `ctl_a` or `ctl_b` clears the stored bit of every cell, so `q` shows `inv_q` in every bit, and no preset is ever applied.
- R2: Mode code 1 (preset by constant load): asserting `ctl_a` drives `q` to all ones whatever `ld` holds; `ctl_b` has no effect on `q`.
- R3: Mode code 2 (preset by inversion): both inversions are forced on, so captured data reaches `q` unchanged, and asserting `ctl_a` drives `q` to all ones; `ld` and `ctl_b` have no effect on `q`.
- R4: Mode code 3 (preset and clear): `ctl_a` drives `q` to all ones and `ctl_b` drives `q` to `inv_q` in every bit; when both are asserted, `ctl_b` wins.
- R5: Mode code 4 (load with clear): `ctl_a` asynchronously makes `q` equal to `ld`, bit by bit; `ctl_b` drives `q` to `inv_q` in every bit and wins over `ctl_a`.
- R6: Mode code 5 (load with preset): both inversions are forced on; `ctl_a` makes `q` equal to `ld`, and `ctl_b` drives `q` to all ones and wins over `ctl_a`.
- R7: Mode code 6 (load-only): `ctl_a` makes `q` equal to `ld`; `ctl_b` has no effect on `q`.
- R8: With no control asserted and `rst_n` high, each rising `clk` edge makes `q` equal to `d` XOR effective `inv_d` XOR effective `inv_q`. The effective enables are the inputs themselves, or ones in modes 2 and 5.
- R9: A rising `clk` edge with `rst_n` low and no control asserted clears the stored bit, so `q` shows the effective `inv_q` in every bit; an asserted control still takes priority over this reset.
- R10: Control effects appear at `q` without waiting for a clock edge, and they hold across clock edges for as long as the control stays asserted. Once the controls are released, the forced value is kept until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Static mode code (0 to 7) |
| inv_d | input | 1 | Static enable: invert data before the flip-flop |
| inv_q | input | 1 | Static enable: invert the flip-flop output |
| ctl_a | input | 1 | First shared asynchronous control line, active high |
| ctl_b | input | 1 | Second shared asynchronous control line, active high |
| d | input | WIDTH | Synchronous data, one bit per cell |
| ld | input | WIDTH | Asynchronous load data, one bit per cell |
| q | output | WIDTH | Visible register outputs |

## Verification
The bench builds the slice with `WIDTH` = 4 and drives load patterns such as 1010 and 0110. With these patterns a single `ctl_a` assertion steers some cells through the set path and others through the reset path at the same moment, with and without the forced inversions. Four cells also let every captured pattern differ from its inverse, so a missing or doubled inversion shows in the output. Controls are raised both in mid-cycle and on a clock edge, and they are held across edges, which exercises the priority between asynchronous forcing, synchronous reset and capture.

// File: rtl/lecell_pkg.sv
`timescale 1ns/1ps
// Package lecell_pkg
// Shared mode codes and helpers for the register slice.
// Assumes the mode input is static while the slice is in use.
package lecell_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_CLR       = 3'd0,
        MODE_PRE_LOAD  = 3'd1,
        MODE_PRE_INV   = 3'd2,
        MODE_PRE_CLR   = 3'd3,
        MODE_LOAD_CLR  = 3'd4,
        MODE_LOAD_PRE  = 3'd5,
        MODE_LOAD_ONLY = 3'd6,
        MODE_SPARE     = 3'd7
    } lecell_mode_e;

    // Modes whose preset is built from the clear path behind inversion
    function automatic logic forces_inversion(lecell_mode_e m);
        return (m == MODE_PRE_INV) || (m == MODE_LOAD_PRE);
    endfunction

endpackage

// File: rtl/lecell_decode.sv
`timescale 1ns/1ps
// Module lecell_decode
// Steers the two shared control lines and one cell's load bit onto the
// set/reset paths of a primitive flip-flop, according to the mode code.
// The outputs are in the stored (pre-output-inversion) domain.
// A load never drives set and reset together; a clear may overlap a set,
// and the flip-flop resolves that in favour of the clear.
module lecell_decode
    import lecell_pkg::*;
(
    input  lecell_mode_e mode,
    input  logic         inv_d,
    input  logic         inv_q,
    input  logic         ctl_a,
    input  logic         ctl_b,
    input  logic         ld,
    output logic         set_raw,
    output logic         rst_raw,
    output logic         inv_d_eff,
    output logic         inv_q_eff
);

    logic one_raw;   // stored value that shows as a visible one
    logic ld_raw;    // stored value that shows as the load bit

    // Effective inversions: the user enables, or forced by the mode
    always_comb begin
        inv_d_eff = inv_d | forces_inversion(mode);
        inv_q_eff = inv_q | forces_inversion(mode);
        one_raw   = ~inv_q_eff;
        ld_raw    = ld ^ inv_q_eff;
    end

    // Mode table: map the control lines to set and reset requests
    always_comb begin
        set_raw = 1'b0;
        rst_raw = 1'b0;
        unique case (mode)
            MODE_PRE_LOAD: begin
                set_raw = ctl_a & one_raw;
                rst_raw = ctl_a & ~one_raw;
            end
            MODE_PRE_INV: begin
                rst_raw = ctl_a;
            end
            MODE_PRE_CLR: begin
                set_raw = ctl_a & one_raw;
                rst_raw = (ctl_a & ~one_raw) | ctl_b;
            end
            MODE_LOAD_CLR, MODE_LOAD_PRE: begin
                set_raw = ctl_a & ld_raw;
                rst_raw = (ctl_a & ~ld_raw) | ctl_b;
            end
            MODE_LOAD_ONLY: begin
                set_raw = ctl_a & ld_raw;
                rst_raw = ctl_a & ~ld_raw;
            end
            default: begin
                rst_raw = ctl_a | ctl_b;
            end
        endcase
    end

endmodule

// File: rtl/lecell_flop.sv
`timescale 1ns/1ps
// Module lecell_flop
// Primitive flip-flop with asynchronous set and reset and a synchronous
// active-low reset. Reset beats set. The output follows a held set or
// reset level, so a set still shows after an overlapping reset is released.
// Assumes set and reset come from glitch-free static decoding.
module lecell_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic set_raw,
    input  logic rst_raw,
    input  logic d_raw,
    output logic q_raw
);

    logic stored;

    // Storage: asynchronous forcing first, then synchronous reset, then capture
    always_ff @(posedge clk or posedge set_raw or posedge rst_raw) begin
        if (rst_raw) begin
            stored <= 1'b0;
        end else if (set_raw) begin
            stored <= 1'b1;
        end else if (!rst_n) begin
            stored <= 1'b0;
        end else begin
            stored <= d_raw;
        end
    end

    // Level view: active forcing overrides the stored bit while held
    always_comb begin
        q_raw = rst_raw ? 1'b0 : (set_raw ? 1'b1 : stored);
    end

endmodule

// File: rtl/lecell_reg.sv
`timescale 1ns/1ps
// Module lecell_reg
// Slice of WIDTH register cells that share the two control lines, the mode
// code and the inversion enables. Each cell has its own data, load and output.
// Assumes mode, inv_d and inv_q are static configuration.
module lecell_reg
    import lecell_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MODE_W-1:0]     mode,
    input  logic                  inv_d,
    input  logic                  inv_q,
    input  logic                  ctl_a,
    input  logic                  ctl_b,
    input  logic [WIDTH-1:0]      d,
    input  logic [WIDTH-1:0]      ld,
    output logic [WIDTH-1:0]      q
);

    localparam int LAST = WIDTH - 1;

    lecell_mode_e mode_e;

    // Type the static mode code once for all cells
    always_comb mode_e = lecell_mode_e'(mode);

    for (genvar i = 0; i <= LAST; i++) begin : g_cell
        logic set_raw, rst_raw, inv_d_eff, inv_q_eff, d_raw, q_raw;

        lecell_decode u_dec (
            .mode      (mode_e),
            .inv_d     (inv_d),
            .inv_q     (inv_q),
            .ctl_a     (ctl_a),
            .ctl_b     (ctl_b),
            .ld        (ld[i]),
            .set_raw   (set_raw),
            .rst_raw   (rst_raw),
            .inv_d_eff (inv_d_eff),
            .inv_q_eff (inv_q_eff)
        );

        // Input inversion ahead of the flip-flop
        always_comb d_raw = d[i] ^ inv_d_eff;

        lecell_flop u_ff (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_raw (set_raw),
            .rst_raw (rst_raw),
            .d_raw   (d_raw),
            .q_raw   (q_raw)
        );

        // Output inversion after the flip-flop
        always_comb q[i] = q_raw ^ inv_q_eff;
    end

endmodule

// File: rtl/lecell_reg_chk.sv
`timescale 1ns/1ps
// Module lecell_reg_chk
// Port-level properties of lecell_reg. Each one checks that a control held
// over two consecutive edges shows its forced value at the output.
module lecell_reg_chk
    import lecell_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [MODE_W-1:0]     mode,
    input logic                  inv_d,
    input logic                  inv_q,
    input logic                  ctl_a,
    input logic                  ctl_b,
    input logic [WIDTH-1:0]      d,
    input logic [WIDTH-1:0]      ld,
    input logic [WIDTH-1:0]      q
);

    logic clr_only_on, pre_a_on, pc_clr_on, lp_pre_on, load_on;

    // Condition decode used by the properties
    always_comb begin
        clr_only_on = ((mode == MODE_CLR) || (mode == MODE_SPARE)) && (ctl_a || ctl_b);
        pre_a_on    = ((mode == MODE_PRE_LOAD) || (mode == MODE_PRE_INV)) && ctl_a;
        pc_clr_on   = ((mode == MODE_PRE_CLR) || (mode == MODE_LOAD_CLR)) && ctl_b;
        lp_pre_on   = (mode == MODE_LOAD_PRE) && ctl_b;
        load_on     = ((mode == MODE_LOAD_CLR) || (mode == MODE_LOAD_PRE) ||
                       (mode == MODE_LOAD_ONLY)) && ctl_a && !ctl_b;
    end

    // R1
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_only_on |=> (!clr_only_on || q == {WIDTH{inv_q}}));

    // R2
    preset_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_a_on |=> (!pre_a_on || q == {WIDTH{1'b1}}));

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_clr_on |=> (!pc_clr_on || q == {WIDTH{inv_q}}));

    // R6
    inv_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_pre_on |=> (!lp_pre_on || q == {WIDTH{1'b1}}));

    // R5
    load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_on |=> (!(load_on && $stable(ld)) || q == ld));

endmodule

bind lecell_reg lecell_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/lecell_reg_tb.sv
`timescale 1ns/1ps
// Bench lecell_reg_tb: directed tasks, one per scenario, each checking itself.
module lecell_reg_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         inv_d = 1'b0, inv_q = 1'b0;
    logic         ctl_a = 1'b0, ctl_b = 1'b0;
    logic [W-1:0] d = '0, ld = '0;
    logic [W-1:0] q;
    int           checks = 0, errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    lecell_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .inv_d(inv_d), .inv_q(inv_q),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .d(d), .ld(ld), .q(q)
    );

    task automatic chk(input string tag, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, q, exp);
        end
    endtask

    // Drive at falling edge, look half a nanosecond later (between edges)
    task automatic mid();
        @(negedge clk);
    endtask

    task automatic look();
        #0.5;
    endtask

    // Capture d with no controls active and check R8 value
    task automatic capture(input logic [W-1:0] val, input logic [W-1:0] exp);
        mid(); ctl_a = 0; ctl_b = 0; d = val;
        @(posedge clk); #1;
        chk("R8 capture", exp);
    endtask

    task automatic t_reset();
        mode = 3'd0; d = '1;
        repeat (2) @(posedge clk);
        #1 chk("R9 reset clear", 4'b0000);
        mid(); mode = 3'd5;
        @(posedge clk); #1 chk("R9 reset under forced inversion", 4'b1111);
        mid(); mode = 3'd3; ctl_a = 1;
        @(posedge clk); #1 chk("R9 control beats reset", 4'b1111);
        mid(); ctl_a = 0; mode = 3'd0; rst_n = 1;
    endtask

    task automatic t_clear_only();
        mode = 3'd0; inv_d = 0; inv_q = 0;
        capture(4'b1111, 4'b1111);
        mid(); ctl_a = 1; look(); chk("R1 ctl_a clears mid-cycle", 4'b0000);
        mid(); ctl_a = 0; look(); chk("R10 clear retained", 4'b0000);
        capture(4'b1011, 4'b1011);
        mid(); ctl_b = 1; look(); chk("R1 ctl_b clears", 4'b0000);
        mid(); ctl_b = 0; inv_q = 1;
        capture(4'b1111, 4'b0000);
        mid(); ctl_b = 1; look(); chk("R1 clear shows inv_q", 4'b1111);
        mid(); ctl_b = 0; inv_q = 0; mode = 3'd7;
        capture(4'b0110, 4'b0110);
        mid(); ctl_b = 1; look(); chk("R1 spare code clears", 4'b0000);
        mid(); ctl_b = 0;
    endtask

    task automatic t_preset_load();
        mode = 3'd1;
        capture(4'b0000, 4'b0000);
        mid(); ld = 4'b0000; ctl_b = 1; look(); chk("R2 ctl_b ignored", 4'b0000);
        mid(); ctl_b = 0; ctl_a = 1; look(); chk("R2 preset", 4'b1111);
        @(posedge clk); #1 chk("R10 preset holds over edge", 4'b1111);
        mid(); ctl_a = 0;
    endtask

    task automatic t_preset_inv();
        mode = 3'd2;
        capture(4'b0101, 4'b0101);
        mid(); ld = 4'b0000; ctl_b = 1; look(); chk("R3 ctl_b and ld ignored", 4'b0101);
        mid(); ctl_b = 0; ctl_a = 1; look(); chk("R3 preset by inversion", 4'b1111);
        mid(); ctl_a = 0;
    endtask

    task automatic t_pre_clr();
        mode = 3'd3;
        capture(4'b0110, 4'b0110);
        mid(); ctl_a = 1; look(); chk("R4 preset", 4'b1111);
        mid(); ctl_b = 1; look(); chk("R4 clear wins", 4'b0000);
        mid(); ctl_a = 0; look();
        mid(); ctl_b = 0; look(); chk("R4 clear retained", 4'b0000);
    endtask

    task automatic t_load_clr();
        mode = 3'd4;
        capture(4'b0000, 4'b0000);
        mid(); ld = 4'b1010; ctl_a = 1; look(); chk("R5 load", 4'b1010);
        mid(); ctl_a = 0; look(); chk("R10 load retained", 4'b1010);
        mid(); ld = 4'b0101; ctl_a = 1; look(); chk("R5 reload", 4'b0101);
        mid(); ctl_b = 1; look(); chk("R5 clear wins", 4'b0000);
        mid(); ctl_a = 0; look();
        mid(); ctl_b = 0;
    endtask

    task automatic t_load_pre();
        mode = 3'd5; inv_d = 0; inv_q = 0;
        capture(4'b0011, 4'b0011);
        mid(); ld = 4'b0110; ctl_a = 1; look(); chk("R6 load through inversion", 4'b0110);
        mid(); ctl_a = 0; look(); chk("R6 load retained", 4'b0110);
        mid(); ctl_b = 1; look(); chk("R6 preset", 4'b1111);
        mid(); ld = 4'b0000; ctl_a = 1; look(); chk("R6 preset wins", 4'b1111);
        mid(); ctl_a = 0; look();
        mid(); ctl_b = 0; look(); chk("R6 preset retained", 4'b1111);
    endtask

    task automatic t_load_only();
        mode = 3'd6;
        capture(4'b1111, 4'b1111);
        mid(); ld = 4'b0110; ctl_b = 1; look(); chk("R7 ctl_b ignored", 4'b1111);
        mid(); ctl_b = 0; ctl_a = 1; look(); chk("R7 load", 4'b0110);
        mid(); ctl_a = 0;
    endtask

    task automatic t_sync_inv();
        mode = 3'd0; inv_d = 1; inv_q = 0;
        capture(4'b0011, 4'b1100);
        mid(); inv_q = 1;
        capture(4'b0011, 4'b0011);
        mid(); inv_d = 0;
        capture(4'b0011, 4'b1100);
        mid(); inv_q = 0;
    endtask

    task automatic t_edge();
        mode = 3'd4;
        capture(4'b0000, 4'b0000);
        @(posedge clk); ld = 4'b1001; d = 4'b0110; ctl_a = 1;
        #1 chk("R10 load at clock edge", 4'b1001);
        @(posedge clk); #1 chk("R10 load holds over edge", 4'b1001);
        mid(); ctl_a = 0;
        @(posedge clk); #1 chk("R8 capture after release", 4'b0110);
    endtask

    initial begin
        t_reset();
        t_clear_only();
        t_preset_load();
        t_preset_inv();
        t_pre_clr();
        t_load_clr();
        t_load_pre();
        t_load_only();
        t_sync_inv();
        t_edge();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule